// File: doc/BRIEF.md
# 1-Wire ROM Search Engine

This block is the master-side sequencer that enumerates every slave on a 1-Wire bus. It does not generate bus waveforms. It drives an external bit-slot master through a small command port that offers three operations: a bus reset with presence sampling, a single-bit write slot and a single-bit read slot. Each operation is handed off with a valid/done handshake.

A pulse on `start` launches a search, and `alarm_sel` picks the command byte. Each pass has four steps:

- reset the bus;
- send the command byte least significant bit first;
- for each of the 64 identity positions, lowest first, read the bit, read its complement, then write the chosen branch direction;
- present the assembled identity with a one-cycle strobe.

Between passes the engine keeps the highest position where it took the 0 branch of a disagreement. That position steers the next pass, so the passes walk the identity tree in a fixed order until no branch is left unexplored.

Top module: `onewire_id_search`

## Requirements
- R1: While and after reset, `busy`, `done`, `no_dev`, `id_valid` and `cmd_valid` are all 0.
- R2: Every pass begins with a reset operation (`cmd_op` = 2'b00). If `cmd_rbit` is 0 when that operation completes (no presence), the search ends with `done` = 1 and `no_dev` = 1, and no identity is presented for that pass.
- R3: After a reset with presence the engine issues 8 write operations (`cmd_op` = 2'b01) carrying the command byte LSB first. The byte is F0h when `alarm_sel` was 0 at `start`, and ECh when it was 1.
- R4: After the command byte, each of 64 positions (position 0 first) uses exactly two read operations (`cmd_op` = 2'b10) followed by one write operation. The written value becomes bit i of the identity for position i.
- R5: A read pair (bit, complement) of (0,1) makes the engine write 0. A pair of (1,0) makes it write 1.
- R6: A read pair of (1,1) aborts the search with `done` = 1 and `no_dev` = 1 and no identity strobe.
- R7: On a (0,0) pair, the written bit depends on the pass. On the first pass it is 0. On later passes it repeats the previous identity's bit below the stored position, is 1 at the stored position, and is 0 above it.
- R8: Each completed pass raises `id_valid` for exactly one cycle with the identity on `id_value`. A pass in which no (0,0) pair was resolved with 0 is the last one, and `done` rises in the same cycle as its `id_valid`.
- R9: The identities of the responding slaves are each presented exactly once, in ascending order of their bit-reversed value.
- R10: `cmd_valid` stays high with `cmd_op` and `cmd_wbit` stable until `cmd_done` is seen with it, and is low in the following cycle.
- R11: `start` has no effect while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new search when idle |
| alarm_sel | input | 1 | 0: normal search byte, 1: alarm-only search byte |
| cmd_valid | output | 1 | Slot operation requested |
| cmd_op | output | 2 | 00 reset, 01 write, 10 read |
| cmd_wbit | output | 1 | Bit to write in a write operation |
| cmd_done | input | 1 | Slot master finished the requested operation |
| cmd_rbit | input | 1 | Read value, or presence (1) after a reset |
| busy | output | 1 | Search in progress |
| id_valid | output | 1 | One-cycle strobe: identity found |
| id_value | output | 64 | Discovered identity, valid with `id_valid` |
| done | output | 1 | Search finished, held until the next start |
| no_dev | output | 1 | Search ended without presence or with an empty read pair |

## Verification
On the final pass the identity strobe and the finished flag must rise together. The decision to stop is taken at the write slot of position 63, where a disagreement resolved at that very slot still has to keep the search going. The scenario table therefore includes slave sets whose only disagreement sits at position 63 and others whose only disagreement sits at position 0. For every strobe, the bench records whether `done` was already high in the same sampled cycle. It requires that flag on the last strobe and its absence on every earlier one.

// File: rtl/ows_pkg.sv
package ows_pkg;

  typedef enum logic [1:0] {
    OP_RESET = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10
  } slot_op_e;

  localparam logic [7:0] CMD_ALL   = 8'hF0;
  localparam logic [7:0] CMD_ALARM = 8'hEC;

  // Branch choice for one position: returns {dir, fork0}.
  // fork0 marks a disagreement that was resolved by taking the 0 branch.
  function automatic logic [1:0] pick_branch(input logic rd_b, input logic rd_c,
                                             input logic known, input logic below_mark,
                                             input logic at_mark, input logic prev);
    logic dir;
    logic split;
    split = 1'b0;
    case ({rd_b, rd_c})
      2'b01:   dir = 1'b0;
      2'b10:   dir = 1'b1;
      2'b11:   dir = 1'b1;
      default: begin
        split = 1'b1;
        if (!known)          dir = 1'b0;
        else if (below_mark) dir = prev;
        else if (at_mark)    dir = 1'b1;
        else                 dir = 1'b0;
      end
    endcase
    return {dir, split & ~dir};
  endfunction

endpackage

// File: rtl/ows_slot_port.sv
module ows_slot_port (
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  input  logic cmd_done,
  output logic cmd_valid,
  output logic fire
);
  logic gap_q;

  assign cmd_valid = want & ~gap_q;
  assign fire      = cmd_valid & cmd_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap_q <= 1'b0;
    else        gap_q <= fire;
  end

  a_r10_gap: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !cmd_valid);
endmodule

// File: rtl/ows_branch.sv
module ows_branch #(
  parameter int ID_W  = 64,
  localparam int IDX_W = $clog2(ID_W)
) (
  input  logic             rd_b,
  input  logic             rd_c,
  input  logic             known,
  input  logic [IDX_W-1:0] pos,
  input  logic [IDX_W-1:0] mark,
  input  logic             prev,
  output logic             dir,
  output logic             fork0
);
  import ows_pkg::*;

  logic below_mark;
  logic at_mark;

  assign below_mark = pos < mark;
  assign at_mark    = pos == mark;

  always_comb begin
    {dir, fork0} = pick_branch(rd_b, rd_c, known, below_mark, at_mark, prev);
  end
endmodule

// File: rtl/ows_path.sv
module ows_path #(
  parameter int ID_W  = 64,
  localparam int IDX_W = $clog2(ID_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             pass_open,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_bit,
  input  logic             wr_fork,
  input  logic             pass_close,
  output logic [ID_W-1:0]  id_q,
  output logic             prev_bit,
  output logic             known,
  output logic [IDX_W-1:0] mark,
  output logic             more
);
  logic [ID_W-1:0]  id_r;
  logic             known_r;
  logic [IDX_W-1:0] mark_r;
  logic [IDX_W-1:0] cand_r;
  logic             cand_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_r    <= '0;
      known_r <= 1'b0;
      mark_r  <= '0;
      cand_r  <= '0;
      cand_v  <= 1'b0;
    end else if (clr) begin
      id_r    <= '0;
      known_r <= 1'b0;
      mark_r  <= '0;
      cand_r  <= '0;
      cand_v  <= 1'b0;
    end else begin
      if (pass_open) cand_v <= 1'b0;
      if (wr_en) begin
        id_r[wr_idx] <= wr_bit;
        if (wr_fork) begin
          cand_r <= wr_idx;
          cand_v <= 1'b1;
        end
      end
      if (pass_close) begin
        known_r <= cand_v;
        mark_r  <= cand_r;
      end
    end
  end

  assign id_q     = id_r;
  assign prev_bit = id_r[wr_idx];
  assign known    = known_r;
  assign mark     = mark_r;
  assign more     = cand_v | (wr_en & wr_fork);

  // R7: recorded 0-branch forks move upward within a pass
  a_r7_ascend: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_fork && cand_v && !pass_open) |-> (wr_idx > cand_r));
endmodule

// File: rtl/onewire_id_search.sv
module onewire_id_search #(
  parameter int ID_W  = 64,
  parameter int CMD_W = 8,
  localparam int IDX_W  = $clog2(ID_W),
  localparam int CBIT_W = $clog2(CMD_W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            alarm_sel,
  output logic            cmd_valid,
  output logic [1:0]      cmd_op,
  output logic            cmd_wbit,
  input  logic            cmd_done,
  input  logic            cmd_rbit,
  output logic            busy,
  output logic            id_valid,
  output logic [ID_W-1:0] id_value,
  output logic            done,
  output logic            no_dev
);
  import ows_pkg::*;

  typedef enum logic [2:0] {
    S_IDLE, S_RST, S_CMD, S_RD0, S_RD1, S_WR, S_END
  } st_e;

  st_e               st;
  logic              alarm_q;
  logic [CBIT_W-1:0] cbit;
  logic [IDX_W-1:0]  idx;
  logic              rd_b, rd_c;
  logic              done_q, nodev_q;

  logic              want, fire;
  logic [CMD_W-1:0]  cmd_byte;
  logic              dec_dir, dec_fork0;
  logic              prev_bit, known, more;
  logic [IDX_W-1:0]  mark;
  logic              pass_open, pass_close, wr_en, clr;
  logic              last_bit, last_cbit;
  logic              abort_pair;

  assign cmd_byte   = CMD_W'(alarm_q ? CMD_ALARM : CMD_ALL);
  assign want       = (st == S_RST) || (st == S_CMD) || (st == S_RD0) ||
                      (st == S_RD1) || (st == S_WR);
  assign last_bit   = idx == IDX_W'(ID_W - 1);
  assign last_cbit  = cbit == CBIT_W'(CMD_W - 1);
  assign clr        = (st == S_IDLE) && start;
  assign pass_open  = (st == S_CMD) && fire && last_cbit;
  assign wr_en      = (st == S_WR) && fire;
  assign pass_close = st == S_END;
  assign abort_pair = (st == S_RD1) && fire && rd_b && cmd_rbit;

  ows_slot_port u_port (
    .clk(clk), .rst_n(rst_n), .want(want), .cmd_done(cmd_done),
    .cmd_valid(cmd_valid), .fire(fire)
  );

  ows_branch #(.ID_W(ID_W)) u_branch (
    .rd_b(rd_b), .rd_c(rd_c), .known(known), .pos(idx), .mark(mark),
    .prev(prev_bit), .dir(dec_dir), .fork0(dec_fork0)
  );

  ows_path #(.ID_W(ID_W)) u_path (
    .clk(clk), .rst_n(rst_n), .clr(clr), .pass_open(pass_open),
    .wr_en(wr_en), .wr_idx(idx), .wr_bit(dec_dir), .wr_fork(dec_fork0),
    .pass_close(pass_close), .id_q(id_value), .prev_bit(prev_bit),
    .known(known), .mark(mark), .more(more)
  );

  always_comb begin
    cmd_op   = OP_RESET;
    cmd_wbit = 1'b0;
    case (st)
      S_CMD: begin cmd_op = OP_WRITE; cmd_wbit = cmd_byte[cbit]; end
      S_WR:  begin cmd_op = OP_WRITE; cmd_wbit = dec_dir;        end
      S_RD0, S_RD1: cmd_op = OP_READ;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      alarm_q <= 1'b0;
      cbit    <= '0;
      idx     <= '0;
      rd_b    <= 1'b0;
      rd_c    <= 1'b0;
      done_q  <= 1'b0;
      nodev_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          alarm_q <= alarm_sel;
          done_q  <= 1'b0;
          nodev_q <= 1'b0;
          st      <= S_RST;
        end
        S_RST: if (fire) begin
          if (cmd_rbit) begin
            cbit <= '0;
            st   <= S_CMD;
          end else begin
            done_q  <= 1'b1;
            nodev_q <= 1'b1;
            st      <= S_IDLE;
          end
        end
        S_CMD: if (fire) begin
          if (last_cbit) begin
            idx <= '0;
            st  <= S_RD0;
          end else begin
            cbit <= cbit + CBIT_W'(1);
          end
        end
        S_RD0: if (fire) begin
          rd_b <= cmd_rbit;
          st   <= S_RD1;
        end
        S_RD1: if (fire) begin
          rd_c <= cmd_rbit;
          if (rd_b && cmd_rbit) begin
            done_q  <= 1'b1;
            nodev_q <= 1'b1;
            st      <= S_IDLE;
          end else begin
            st <= S_WR;
          end
        end
        S_WR: if (fire) begin
          if (last_bit) begin
            done_q <= ~more;
            st     <= S_END;
          end else begin
            idx <= idx + IDX_W'(1);
            st  <= S_RD0;
          end
        end
        S_END: st <= done_q ? S_IDLE : S_RST;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy     = st != S_IDLE;
  assign id_valid = st == S_END;
  assign done     = done_q;
  assign no_dev   = nodev_q;

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_done) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_wbit)));

  a_r8_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |=> !id_valid);

  a_r8_done_last: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && !no_dev) |-> id_valid);

  a_r2_nodev_done: assert property (@(posedge clk) disable iff (!rst_n)
    no_dev |-> done);

  a_r6_abort: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pair |=> (done && no_dev && !busy && !id_valid));

  a_r11_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !id_valid && start) |=> busy);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_valid);
endmodule

// File: tb/sim_onewire_id_search.sv
module sim_onewire_id_search;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  typedef struct packed {
    logic [2:0]       n;
    logic [3:0]       amask;
    logic             asel;
    logic [3:0][63:0] ids;
  } scen_t;

  localparam int NSCEN = 6;
  localparam scen_t TBL [NSCEN] = '{
    '{n:3'd1, amask:4'b0000, asel:1'b0,
      ids:{64'h0, 64'h0, 64'h0, 64'h1122_3344_5566_7728}},
    '{n:3'd4, amask:4'b0000, asel:1'b0,
      ids:{64'h8800_0000_7777_0088, 64'hAF00_0000_0F0F_F028,
           64'h9C00_0000_ABCD_0055, 64'h3A00_0000_1234_5628}},
    '{n:3'd2, amask:4'b0000, asel:1'b0,
      ids:{64'h0, 64'h0, 64'h8000_0000_0000_0001, 64'h0000_0000_0000_0001}},
    '{n:3'd2, amask:4'b0000, asel:1'b0,
      ids:{64'h0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFE}},
    '{n:3'd4, amask:4'b0101, asel:1'b1,
      ids:{64'h8800_0000_7777_0088, 64'hAF00_0000_0F0F_F028,
           64'h9C00_0000_ABCD_0055, 64'h3A00_0000_1234_5628}},
    '{n:3'd3, amask:4'b0000, asel:1'b0,
      ids:{64'h0, 64'h0000_0000_0000_0020, 64'h0000_0000_0000_0030,
           64'h0000_0000_0000_0010}}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic alarm_sel = 1'b0;
  logic cmd_done = 1'b0;
  logic cmd_rbit = 1'b0;
  logic cmd_valid, cmd_wbit, busy, id_valid, done, no_dev;
  logic [1:0] cmd_op;
  logic [63:0] id_value;

  always #(CLK_PERIOD/2) clk = ~clk;

  onewire_id_search u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .alarm_sel(alarm_sel),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_wbit(cmd_wbit),
    .cmd_done(cmd_done), .cmd_rbit(cmd_rbit), .busy(busy),
    .id_valid(id_valid), .id_value(id_value), .done(done), .no_dev(no_dev)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // slave population seen by the bus model
  logic [63:0] sids [4];
  int          nslv = 0;
  logic [3:0]  smask = '0;
  logic [7:0]  exp_byte = 8'hF0;

  // bus model state
  int          bad_byte = 0;
  int          proto = 0;
  logic [3:0]  act;
  logic [7:0]  rx_byte;
  int          bcnt, bitpos, slotk, nslot;
  bit          phase;

  // monitor state
  logic [63:0] found [8];
  bit          dflag [8];
  int          nfound = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act_v,
                     input logic [63:0] exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act_v, exp_v);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WATCHDOG) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (start && !busy) nfound = 0;
    if (id_valid && nfound < 8) begin
      found[nfound] = id_value;
      dflag[nfound] = done;
      nfound++;
    end
  end

  // bit-slot master and slave population model
  initial begin
    act = '0; rx_byte = '0; bcnt = 0; bitpos = 0; slotk = 0; nslot = 0; phase = 0;
    forever begin
      @(negedge clk);
      cmd_done = 1'b0;
      if (cmd_valid) begin
        repeat (nslot % 3) @(negedge clk);
        case (cmd_op)
          2'b00: begin
            cmd_rbit = nslv > 0;
            bcnt = 0; phase = 0; act = '0;
          end
          2'b01: begin
            if (!phase) begin
              rx_byte[bcnt] = cmd_wbit;
              bcnt++;
              if (bcnt == 8) begin
                phase = 1; bitpos = 0; slotk = 0;
                if (rx_byte != exp_byte) bad_byte++;
                for (int j = 0; j < 4; j++)
                  act[j] = (j < nslv) && ((rx_byte == 8'hF0) ||
                           (rx_byte == 8'hEC && smask[j]));
              end
            end else begin
              if (slotk != 2 || bitpos > 63) proto++;
              for (int j = 0; j < 4; j++)
                if (act[j] && sids[j][bitpos[5:0]] != cmd_wbit) act[j] = 1'b0;
              bitpos++; slotk = 0;
            end
            cmd_rbit = 1'b0;
          end
          default: begin
            if (!phase || slotk > 1) proto++;
            cmd_rbit = 1'b1;
            for (int j = 0; j < 4; j++)
              if (act[j]) cmd_rbit = cmd_rbit &
                (slotk == 0 ? sids[j][bitpos[5:0]] : ~sids[j][bitpos[5:0]]);
            slotk++;
          end
        endcase
        cmd_done = 1'b1;
        nslot++;
      end
    end
  end

  function automatic logic [63:0] brev(input logic [63:0] v);
    logic [63:0] r;
    for (int k = 0; k < 64; k++) r[k] = v[63-k];
    return r;
  endfunction

  task automatic run(input logic asel, input bit kick);
    @(negedge clk);
    exp_byte = asel ? 8'hEC : 8'hF0;
    bad_byte = 0; proto = 0;
    start = 1'b1; alarm_sel = asel;
    @(negedge clk);
    start = 1'b0;
    if (kick) begin
      repeat (500) @(negedge clk);
      start = 1'b1; alarm_sel = ~asel;
      @(negedge clk);
      start = 1'b0; alarm_sel = asel;
    end
    do @(negedge clk); while (!done);
    repeat (2) @(negedge clk);
  endtask

  task automatic judge(input scen_t s, input string tag);
    logic [63:0] ex [4];
    logic [63:0] t;
    int ne = 0;
    for (int j = 0; j < 4; j++)
      if (j < int'(s.n) && (!s.asel || s.amask[j])) begin ex[ne] = s.ids[j]; ne++; end
    for (int a = 0; a < ne; a++)
      for (int b = 0; b < ne - 1 - a; b++)
        if (brev(ex[b]) > brev(ex[b+1])) begin t = ex[b]; ex[b] = ex[b+1]; ex[b+1] = t; end
    chk(nfound == ne, {tag, " R9 count"}, 64'(nfound), 64'(ne));
    for (int a = 0; a < ne && a < nfound; a++) begin
      chk(found[a] == ex[a], {tag, " R7 R9 identity"}, found[a], ex[a]);
      chk(dflag[a] == (a == ne - 1), {tag, " R8 done with last strobe"},
          64'(dflag[a]), 64'(a == ne - 1));
    end
    chk(no_dev == 1'b0, {tag, " R2 no_dev clear"}, 64'(no_dev), 64'd0);
    chk(bad_byte == 0, {tag, " R3 command byte"}, 64'(bad_byte), 64'd0);
    chk(proto == 0, {tag, " R4 R5 slot order"}, 64'(proto), 64'd0);
    chk(busy == 1'b0, {tag, " R8 idle after done"}, 64'(busy), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({busy, done, no_dev, id_valid, cmd_valid} == 5'b0, "R1 reset outputs",
        64'({busy, done, no_dev, id_valid, cmd_valid}), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({busy, done, no_dev, id_valid, cmd_valid} == 5'b0, "R1 after reset",
        64'({busy, done, no_dev, id_valid, cmd_valid}), 64'd0);

    for (int i = 0; i < NSCEN; i++) begin
      for (int j = 0; j < 4; j++) sids[j] = TBL[i].ids[j];
      nslv = int'(TBL[i].n);
      smask = TBL[i].amask;
      run(TBL[i].asel, 1'b0);
      judge(TBL[i], $sformatf("scen%0d", i));
    end

    // R2 empty bus: no presence
    nslv = 0;
    run(1'b0, 1'b0);
    chk(done && no_dev, "R2 empty bus flags", 64'({done, no_dev}), 64'b11);
    chk(nfound == 0, "R2 no identity on empty bus", 64'(nfound), 64'd0);

    // R6 presence but no slave answers the alarm search: pair (1,1)
    for (int j = 0; j < 4; j++) sids[j] = TBL[1].ids[j];
    nslv = 2; smask = 4'b0000;
    run(1'b1, 1'b0);
    chk(done && no_dev, "R6 empty pair aborts", 64'({done, no_dev}), 64'b11);
    chk(nfound == 0, "R6 no identity after abort", 64'(nfound), 64'd0);
    chk(bad_byte == 0, "R3 alarm byte ECh", 64'(bad_byte), 64'd0);

    // R11 start pulse during a search is ignored
    nslv = 4; smask = 4'b0001;
    run(1'b0, 1'b1);
    judge(TBL[1], "R11 restart ignored");

    // R10 idle after all runs: no pending request
    chk(cmd_valid == 1'b0, "R10 no request when idle", 64'(cmd_valid), 64'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule